// File: doc/BRIEF.md
# Audio Clock-Domain Elastic Buffer

This block moves serial audio samples from a receive clock that was recovered from a line, and so carries jitter, into a steady local playback clock. The write side turns the incoming bit stream into whole sample words. A word strobe on the first bit of each sample frames the stream, and every finished word goes into a small dual-clock FIFO. The read side runs entirely on the local clock. It produces one sample period every `SAMPLE_W` bit ticks and shifts each word out MSB first, with its own word strobe.

Neither side can stall the other. The reader starts only once the FIFO holds half its capacity, which gives the two clocks room to drift. When the reader finds the FIFO empty, it plays a silent word and waits for the half level again. When a word arrives to a full FIFO, that word is thrown away. Each of these two events sets a sticky flag in its own clock domain, and a synchronous clear input in that domain resets the flag.

Top module: `audio_elastic_buf`

## Requirements
- R1: After reset, `rd_bit`, `rd_strobe`, `wr_ovf`, `rd_unf` and `rd_running` are all 0.
- R2: On each `wr_bit_en` cycle one bit is sampled. A bit with `wr_strobe` high starts a new word, and the 24 sampled bits from that bit onward form the word, MSB first. Bits that arrive before any strobe are ignored.
- R3: The FIFO holds 16 words. Words leave in the order they were accepted, with none lost or repeated.
- R4: While waiting, the reader pops nothing and keeps `rd_running` at 0 until at least 8 words are stored. It then starts at the next sample-period boundary.
- R5: A sample period is 24 `rd_bit_en` ticks. On the first tick of each period `rd_strobe` is 1 and the word's MSB appears on `rd_bit`. The remaining bits follow MSB first, with `rd_strobe` at 0.
- R6: When the reader is running and finds the FIFO empty at a period boundary, it outputs an all-zero word for that period. `rd_running` then drops to 0 and the reader waits for 8 words again.
- R7: A word that completes while the FIFO is full is discarded, and the writer is never stalled. The 16 stored words remain intact.
- R8: `wr_ovf` goes to 1 on a discarded word and stays at 1 until `wr_ovf_clr` is sampled high.
- R9: `rd_unf` goes to 1 on a muted period and stays at 1 until `rd_unf_clr` is sampled high.
- R10: Periods played while waiting output zero words and do not set `rd_unf`.
- R11: The write and read clocks may be unrelated. Pointers cross between them as Gray codes through two-flop synchronizers, and a clock offset of a few hundred ppm keeps the order and contents of the words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receive-domain clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_bit_en | input | 1 | Input bit is valid this cycle |
| wr_bit | input | 1 | Serial input data |
| wr_strobe | input | 1 | Marks the first bit of an input word |
| wr_ovf_clr | input | 1 | Clears `wr_ovf` |
| wr_ovf | output | 1 | Sticky overrun flag |
| rd_clk | input | 1 | Local playback clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_bit_en | input | 1 | Output bit tick |
| rd_bit | output | 1 | Serial output data |
| rd_strobe | output | 1 | Marks the first bit of an output word |
| rd_unf_clr | input | 1 | Clears `rd_unf` |
| rd_unf | output | 1 | Sticky underrun flag |
| rd_running | output | 1 | Reader is popping words |

## Verification
Two events can land at the same sample boundary. A word can be completing on the write side while the reader samples its level and sees the FIFO empty, and the reader can decide to mute in the same period that flag clearing happens. Writer gaps of several sample periods inside a long random stream create these collisions, with the read clock about 300 ppm slower than the write clock. The outcome is judged at the ports. A word that arrives late must still come out afterwards, in order. Every muted period must be all zeros and must coincide with `rd_running` falling and `rd_unf` being set.

// File: rtl/aeb_pkg.sv
// Shared types for the audio elastic buffer.
// Assumes nothing beyond a standard SystemVerilog compile.
package aeb_pkg;
    typedef enum logic {
        RD_WAIT = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_t;
endpackage

// File: rtl/aeb_sync.sv
// Multi-stage synchronizer for a Gray-coded vector.
// Assumes the source changes by at most one bit per source clock.
module aeb_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Capture the previous stage, or the input for the first one.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[s] <= '0;
                else if (s == 0)
                    stage[s] <= d;
                else
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/aeb_deser.sv
// Serial-to-parallel word assembler on the receive clock.
// Assumes W >= 2; a strobe bit always restarts the word.
module aeb_deser #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         bit_in,
    input  logic         strobe,
    output logic         push,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    // Shift bits in, release a word when the W-th bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sh   <= '0;
            push <= 1'b0;
            word <= '0;
        end else begin
            push <= 1'b0;
            if (bit_en) begin
                if (strobe) begin
                    sh  <= {{(W-1){1'b0}}, bit_in};
                    cnt <= CW'(1);
                end else if (cnt != '0) begin
                    sh <= {sh[W-2:0], bit_in};
                    if (cnt == CW'(W-1)) begin
                        push <= 1'b1;
                        word <= {sh[W-2:0], bit_in};
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
            end
        end
    end

    // R2: a word is released only in the cycle after a sampled bit
    a_r2_push_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(bit_en) && !$past(strobe));
    // R2: the bit count never passes the word length
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(W));
endmodule

// File: rtl/aeb_fifo.sv
// Dual-clock word FIFO with Gray pointers and a sticky drop flag.
// Assumes AW >= 2; a push into a full FIFO is discarded, never stalled.
module aeb_fifo #(
    parameter int W  = 24,
    parameter int AW = 4
) (
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         ovf_clr,
    output logic         ovf,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic [AW:0]  level
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, wgray_r;
    logic          full;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    assign full = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

    // Store an accepted word.
    always_ff @(posedge wr_clk) begin
        if (push && !full)
            mem[wbin[AW-1:0]] <= wdata;
    end

    // Advance the write pointer on an accepted word.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push && !full) begin
            wbin  <= wbin + PW'(1);
            wgray <= b2g(wbin + PW'(1));
        end
    end

    // Sticky drop flag; setting wins over clearing.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n)
            ovf <= 1'b0;
        else if (push && full)
            ovf <= 1'b1;
        else if (ovf_clr)
            ovf <= 1'b0;
    end

    // Advance the read pointer on a pop.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop && level != '0) begin
            rbin  <= rbin + PW'(1);
            rgray <= b2g(rbin + PW'(1));
        end
    end

    aeb_sync #(.W(PW), .STAGES(2)) u_sync_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_w));
    aeb_sync #(.W(PW), .STAGES(2)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_r));

    assign level = g2b(wgray_r) - rbin;
    assign rdata = mem[rbin[AW-1:0]];

    // R3: the writer never gets more than DEPTH words ahead of the reader
    a_r3_depth_bound: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wbin - g2b(rgray_w)) <= PW'(DEPTH));
    // R7: a discarded word leaves the write pointer where it was
    a_r7_drop_holds_ptr: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (push && full) |=> $stable(wbin) && ovf);
    // R3: the read side never sees more than DEPTH words
    a_r3_level_bound: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        level <= PW'(DEPTH));
    // R6: no pop is ever requested from an empty FIFO
    a_r6_no_pop_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        pop |-> level != '0);
endmodule

// File: rtl/aeb_reader.sv
// Playback-side sequencer: prefill wait, one pop per sample period,
// MSB-first serializer, mute on underrun.
// Assumes bit_en is a tick on the local clean clock.
module aeb_reader
    import aeb_pkg::*;
#(
    parameter int W  = 24,
    parameter int AW = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic [AW:0]  level,
    input  logic [W-1:0] rdata,
    input  logic         unf_clr,
    output logic         pop,
    output logic         out_bit,
    output logic         out_strobe,
    output logic         unf,
    output logic         running
);
    localparam int PW   = AW + 1;
    localparam int HALF = (1 << AW) / 2;
    localparam int IW   = $clog2(W);

    rd_state_t     state;
    logic [IW-1:0] idx;
    logic [W-1:0]  sh;
    logic          period_start, mute, start_ok;

    assign period_start = bit_en && (idx == '0);
    assign start_ok     = (level >= PW'(HALF));
    assign pop  = period_start && (((state == RD_RUN) && (level != '0)) ||
                                   ((state == RD_WAIT) && start_ok));
    assign mute = period_start && (state == RD_RUN) && (level == '0);
    assign running = (state == RD_RUN);
    assign out_bit = sh[W-1];

    // Count bit ticks within a sample period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (bit_en)
            idx <= (idx == IW'(W-1)) ? '0 : idx + IW'(1);
    end

    // Move between waiting and running at period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= RD_WAIT;
        else if (period_start) begin
            if (state == RD_WAIT && start_ok)
                state <= RD_RUN;
            else if (mute)
                state <= RD_WAIT;
        end
    end

    // Load a word or silence at a boundary, shift otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            out_strobe <= 1'b0;
        end else if (bit_en) begin
            if (idx == '0) begin
                sh         <= pop ? rdata : '0;
                out_strobe <= 1'b1;
            end else begin
                sh         <= {sh[W-2:0], 1'b0};
                out_strobe <= 1'b0;
            end
        end
    end

    // Sticky underrun flag; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unf <= 1'b0;
        else if (mute)
            unf <= 1'b1;
        else if (unf_clr)
            unf <= 1'b0;
    end

    // R6: a muted period loads silence and raises the frame strobe
    a_r6_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> (sh == '0) && out_strobe && !running);
    // R9: a muted period leaves the underrun flag set
    a_r9_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> unf);
    // R4: running only begins with at least half the FIFO filled
    a_r4_start_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(level) >= PW'(HALF));
    // R5: the strobe is low on every bit but the first
    a_r5_strobe_first: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && idx != '0) |=> !out_strobe);
endmodule

// File: rtl/audio_elastic_buf.sv
// Top of the audio elastic buffer: deserializer, dual-clock FIFO, reader.
// Assumes wr_* and rd_* signals belong to their own clock domains.
module audio_elastic_buf #(
    parameter int SAMPLE_W = 24,
    parameter int DEPTH_LG = 4
) (
    input  logic wr_clk,
    input  logic wr_rst_n,
    input  logic wr_bit_en,
    input  logic wr_bit,
    input  logic wr_strobe,
    input  logic wr_ovf_clr,
    output logic wr_ovf,
    input  logic rd_clk,
    input  logic rd_rst_n,
    input  logic rd_bit_en,
    output logic rd_bit,
    output logic rd_strobe,
    input  logic rd_unf_clr,
    output logic rd_unf,
    output logic rd_running
);
    logic                push;
    logic [SAMPLE_W-1:0] wword, rword;
    logic                pop;
    logic [DEPTH_LG:0]   level;

    aeb_deser #(.W(SAMPLE_W)) u_deser (
        .clk(wr_clk), .rst_n(wr_rst_n), .bit_en(wr_bit_en),
        .bit_in(wr_bit), .strobe(wr_strobe), .push(push), .word(wword));

    aeb_fifo #(.W(SAMPLE_W), .AW(DEPTH_LG)) u_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .push(push), .wdata(wword),
        .ovf_clr(wr_ovf_clr), .ovf(wr_ovf),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .pop(pop), .rdata(rword),
        .level(level));

    aeb_reader #(.W(SAMPLE_W), .AW(DEPTH_LG)) u_reader (
        .clk(rd_clk), .rst_n(rd_rst_n), .bit_en(rd_bit_en), .level(level),
        .rdata(rword), .unf_clr(rd_unf_clr), .pop(pop), .out_bit(rd_bit),
        .out_strobe(rd_strobe), .unf(rd_unf), .running(rd_running));
endmodule

// File: tb/sim_audio_elastic_buf.sv
`timescale 1ps/1ps
module sim_audio_elastic_buf;
    localparam int CLK_PERIOD    = 10000;
    localparam int RD_CLK_PERIOD = 10003;
    localparam int W             = 24;
    localparam int CAP           = 16;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst_n = 0, rd_rst_n = 0;
    logic wr_bit_en = 0, wr_bit = 0, wr_strobe = 0, wr_ovf_clr = 0;
    logic rd_bit_en = 0, rd_unf_clr = 0;
    logic wr_ovf, rd_bit, rd_strobe, rd_unf, rd_running;

    int checks = 0, failures = 0;
    logic [W-1:0] exp_q [$];
    bit rd_gate = 0, clr_req = 0, done = 0;
    int mute_cnt = 0, idle_cnt = 0;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_CLK_PERIOD/2) rd_clk = ~rd_clk;

    audio_elastic_buf u0 (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_bit_en(wr_bit_en),
        .wr_bit(wr_bit), .wr_strobe(wr_strobe), .wr_ovf_clr(wr_ovf_clr),
        .wr_ovf(wr_ovf), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .rd_bit_en(rd_bit_en), .rd_bit(rd_bit), .rd_strobe(rd_strobe),
        .rd_unf_clr(rd_unf_clr), .rd_unf(rd_unf), .rd_running(rd_running));

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rand_word();
        return W'($urandom) | W'(1);
    endfunction

    // Send one word serially, 4 write clocks per bit; keep=1 models acceptance.
    task automatic send_word(input logic [W-1:0] w, input bit keep);
        for (int b = 0; b < W; b++) begin
            @(negedge wr_clk);
            wr_bit_en = 1; wr_bit = w[W-1-b]; wr_strobe = (b == 0);
            @(negedge wr_clk);
            wr_bit_en = 0; wr_strobe = 0;
            repeat (2) @(negedge wr_clk);
        end
        if (keep) exp_q.push_back(w);
    endtask

    task automatic wait_mutes(input int target);
        for (int i = 0; i < 40000 && mute_cnt < target; i++) @(negedge rd_clk);
    endtask

    // Read-side tick generator and output monitor.
    initial begin
        int div = 0, mcnt = 0;
        bit mmute = 0, munf = 0, prev_run = 0;
        logic [W-1:0] mword = '0;
        forever begin
            @(negedge rd_clk);
            rd_unf_clr = clr_req; clr_req = 0;
            if (rd_bit_en) begin
                if (rd_strobe) begin
                    mword = W'(rd_bit); mcnt = 1;
                    mmute = prev_run && !rd_running;
                    munf = rd_unf; prev_run = rd_running;
                end else if (mcnt > 0) begin
                    mword = {mword[W-2:0], rd_bit}; mcnt++;
                end
                if (mcnt == W) begin
                    mcnt = 0;
                    if (mmute) begin
                        check(mword == '0, "R6 muted word", mword, 0);
                        check(munf, "R9 unf set on mute", munf, 1);
                        mute_cnt++; clr_req = 1;
                    end else begin
                        check(!munf, "R9 unf cleared", munf, 0);
                        if (mword != '0) begin
                            if (exp_q.size() == 0)
                                check(0, "R3 unexpected word", mword, 0);
                            else begin
                                check(mword == exp_q[0], "R3/R5 word order", mword, exp_q[0]);
                                void'(exp_q.pop_front());
                            end
                        end else begin
                            check(!prev_run, "R10 idle silence", prev_run, 0);
                            idle_cnt++;
                        end
                    end
                end
            end
            rd_bit_en = rd_gate && (div == 3);
            div = rd_gate ? (div + 1) % 4 : 0;
        end
    end

    initial begin
        #(longint'(CLK_PERIOD) * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (5) @(negedge wr_clk);
        wr_rst_n = 1;
        @(negedge rd_clk); rd_rst_n = 1;
        repeat (3) @(negedge rd_clk);
        // R1 reset state
        check(rd_bit == 0, "R1 rd_bit", rd_bit, 0);
        check(rd_strobe == 0, "R1 rd_strobe", rd_strobe, 0);
        check(wr_ovf == 0, "R1 wr_ovf", wr_ovf, 0);
        check(rd_unf == 0, "R1 rd_unf", rd_unf, 0);
        check(rd_running == 0, "R1 rd_running", rd_running, 0);

        // R7/R8: overrun with reader halted, 20 words into 16 slots
        for (int i = 0; i < 20; i++) send_word(rand_word(), i < CAP);
        repeat (4) @(negedge wr_clk);
        check(wr_ovf == 1, "R8 ovf set", wr_ovf, 1);
        @(negedge wr_clk); wr_ovf_clr = 1;
        @(negedge wr_clk); wr_ovf_clr = 0;
        @(negedge wr_clk);
        check(wr_ovf == 0, "R8 ovf cleared", wr_ovf, 0);
        rd_gate = 1;
        wait_mutes(1);
        check(mute_cnt == 1, "R6 mute after drain", mute_cnt, 1);
        check(exp_q.size() == 0, "R7 all 16 kept words played", exp_q.size(), 0);

        // R2/R4: stray bits then 7 words; reader must stay waiting
        for (int b = 0; b < 5; b++) begin
            @(negedge wr_clk); wr_bit_en = 1; wr_bit = 1;
            @(negedge wr_clk); wr_bit_en = 0;
        end
        for (int i = 0; i < 7; i++) send_word(rand_word(), 1);
        repeat (600) @(negedge rd_clk);
        check(rd_running == 0, "R4 waits below half", rd_running, 0);
        check(exp_q.size() == 7, "R4 nothing popped", exp_q.size(), 7);
        send_word(rand_word(), 1);
        wait_mutes(2);
        check(exp_q.size() == 0, "R4 start at half and drain", exp_q.size(), 0);
        check(idle_cnt > 0, "R10 idle periods seen", idle_cnt, 1);

        // R11: long random stream with gaps, clocks 300 ppm apart
        for (int i = 0; i < 150; i++) begin
            if (($urandom % 16) == 0) repeat (12 * W * 4) @(negedge wr_clk);
            send_word(rand_word(), 1);
        end
        for (int i = 0; i < 8; i++) send_word(rand_word(), 1);
        for (int i = 0; i < 40000 && exp_q.size() != 0; i++) @(negedge rd_clk);
        repeat (300) @(negedge rd_clk);
        check(exp_q.size() == 0, "R11 stream delivered", exp_q.size(), 0);
        check(wr_ovf == 0, "R7 no spurious drop", wr_ovf, 0);
        check(mute_cnt > 2, "R6 gaps produced mutes", mute_cnt, 3);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule